// File: doc/BRIEF.md
# Busy-polled indirect register access bridge

This block lets a host with a narrow, byte-wide register bus reach a 128-entry internal register array that it cannot address directly. The host sees a status register, a control register and a data register. It loads the data register (for a write) and then writes the control register with a direction bit and a 7-bit indirect address. That control write starts a transfer, and the transfer then finishes in the background while the host polls a BUSY flag. When BUSY drops, the write has landed in the array, or the read value is waiting in the data register.

The internal array is a synchronous memory whose access latency is set by a parameter (1 to 16 cycles). A sequencer state machine has three states. ST_IDLE waits for a control write. ST_ISSUE presents the request to the memory for one cycle. ST_WAIT waits for the memory's completion strobe. The transitions are as follows. ST_IDLE moves to ST_ISSUE on an accepted control write. ST_ISSUE always moves to ST_WAIT. ST_WAIT returns to ST_IDLE on completion. ST_WAIT also returns to ST_IDLE on a timeout abort when no completion has arrived within TMO_CYCLES busy cycles. A timeout also flushes the memory's pending completion.

Register offsets on `host_addr` are 0 for status, 1 for control and 2 for data. Offset 3 is unused. Status bits are bit 0 BUSY, bit 1 overrun and bit 2 timeout. The control byte is bit 7 direction (1 = read, 0 = write) and bits 6:0 the indirect address.

Top module: `ind_bridge`

## Requirements
- R1: After reset, status, control and data all read 0, and every array entry holds 0.
- R2: A control write made while BUSY is 0 is accepted, and BUSY (status bit 0) reads 1 immediately after the accepting clock edge.
- R3: A transfer that completes keeps BUSY at 1 for exactly LATENCY+1 cycles, then BUSY returns to 0.
- R4: A transfer with control bit 7 = 0 stores the data register's value into the array entry selected by control bits 6:0.
- R5: A transfer with control bit 7 = 1 loads the selected array entry into the data register on the completing cycle only. While BUSY is 1, the data register keeps its previous value.
- R6: A control write while BUSY is 1 is ignored: the control readback and the transfer in flight are unchanged, and status bit 1 (overrun) is set and stays set.
- R7: Writing status with bit 1 = 1 clears overrun. Writing status with bit 1 = 0 leaves it set.
- R8: A data-register write while BUSY is 1 is ignored. A write in flight stores the value loaded before it started, and a read in flight returns the array value.
- R9: If no completion arrives within TMO_CYCLES busy cycles, the transfer aborts. BUSY reads 1 for exactly TMO_CYCLES cycles, status bit 2 (timeout) is set, and the data register is unchanged. Writing status with bit 2 = 1 clears the timeout flag.
- R10: Offset 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Host register offset (0 status, 1 control, 2 data, 3 unused) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the register at `host_addr`, combinational |

## Verification
The hardest situation to reach is the timeout abort. With any legal memory latency, a transfer completes long before the 200-cycle budget. The bench therefore builds a second instance whose latency is longer than its timeout budget, so that every transfer on it aborts. The bench then checks the exact busy length, the sticky flag and the untouched data register. Collisions with a busy transfer are created by issuing control and data writes on the cycles just after a transfer has started. The result of the original transfer is then compared against the array values, which are computed arithmetically from an exhaustive write sweep of all 128 addresses.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    localparam logic [1:0] OFS_STATUS = 2'd0;
    localparam logic [1:0] OFS_CTRL   = 2'd1;
    localparam logic [1:0] OFS_DATA   = 2'd2;

    localparam int ST_BIT_BUSY = 0;
    localparam int ST_BIT_OVR  = 1;
    localparam int ST_BIT_TMO  = 2;
endpackage

// File: rtl/ibr_mem.sv
module ibr_mem #(
    parameter int AW  = 7,
    parameter int DW  = 8,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          flush,
    output logic          vld,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]  arr [DEPTH];
    logic [DW-1:0]  rd_q;
    logic [LAT-1:0] vpipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
            rd_q <= '0;
        end else if (req) begin
            if (we) arr[addr] <= wdata;
            rd_q <= arr[addr];
        end
    end

    generate
        if (LAT == 1) begin : g_lat_one
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vpipe <= '0;
                else                 vpipe <= req;
            end
        end else begin : g_lat_many
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vpipe <= '0;
                else                 vpipe <= {vpipe[LAT-2:0], req};
            end
        end
    endgenerate

    assign vld   = vpipe[LAT-1];
    assign rdata = rd_q;
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int TMO_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_vld,
    output logic busy,
    output logic mem_req,
    output logic done,
    output logic tmo_evt,
    output logic flush
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          expired;

    assign expired = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_vld || expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        mem_req = 1'b0;
        done    = 1'b0;
        tmo_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                done    = mem_vld;
                tmo_evt = !mem_vld && expired;
            end
            default:  ;
        endcase
        flush = tmo_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (state_q == ST_IDLE)        cnt_q <= '0;
        else if (!expired)                  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge
    import ibr_pkg::*;
#(
    parameter int AW         = 7,
    parameter int DW         = 8,
    parameter int LATENCY    = 4,
    parameter int TMO_CYCLES = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr_en,
    input  logic [1:0]   host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic          busy, mem_req, xfer_done, tmo_evt, flush, mem_vld;
    logic          ctrl_rw_q;
    logic [AW-1:0] ctrl_addr_q;
    logic [DW-1:0] data_q, mem_rdata;
    logic          ovr_q, tmo_q;
    logic          wr_status, wr_ctrl, wr_data, start;

    assign wr_status = host_wr_en && (host_addr == OFS_STATUS);
    assign wr_ctrl   = host_wr_en && (host_addr == OFS_CTRL);
    assign wr_data   = host_wr_en && (host_addr == OFS_DATA);
    assign start     = wr_ctrl && !busy;

    ibr_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mem_vld (mem_vld),
        .busy    (busy),
        .mem_req (mem_req),
        .done    (xfer_done),
        .tmo_evt (tmo_evt),
        .flush   (flush)
    );

    ibr_mem #(.AW(AW), .DW(DW), .LAT(LATENCY)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mem_req),
        .we    (!ctrl_rw_q),
        .addr  (ctrl_addr_q),
        .wdata (data_q),
        .flush (flush),
        .vld   (mem_vld),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rw_q   <= 1'b0;
            ctrl_addr_q <= '0;
        end else if (start) begin
            ctrl_rw_q   <= host_wdata[DW-1];
            ctrl_addr_q <= host_wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (xfer_done && ctrl_rw_q) data_q <= mem_rdata;
        else if (wr_data && !busy)       data_q <= host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (wr_ctrl && busy)                       ovr_q <= 1'b1;
            else if (wr_status && host_wdata[ST_BIT_OVR]) ovr_q <= 1'b0;
            if (tmo_evt)                               tmo_q <= 1'b1;
            else if (wr_status && host_wdata[ST_BIT_TMO]) tmo_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            OFS_STATUS: begin
                host_rdata[ST_BIT_BUSY] = busy;
                host_rdata[ST_BIT_OVR]  = ovr_q;
                host_rdata[ST_BIT_TMO]  = tmo_q;
            end
            OFS_CTRL: begin
                host_rdata[DW-1]   = ctrl_rw_q;
                host_rdata[AW-1:0] = ctrl_addr_q;
            end
            OFS_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk
    import ibr_pkg::*;
#(
    parameter int AW         = 7,
    parameter int DW         = 8,
    parameter int TMO_CYCLES = 200
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr_en,
    input logic [1:0]    host_addr,
    input logic [DW-1:0] host_wdata,
    input logic          busy,
    input logic          ovr_q,
    input logic          xfer_done,
    input logic          ctrl_rw_q,
    input logic [AW-1:0] ctrl_addr_q,
    input logic [DW-1:0] data_q
);
    localparam int BW = $clog2(TMO_CYCLES + 2);
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_addr == OFS_CTRL && !busy) |=> busy);

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_addr == OFS_CTRL && busy) |=> ovr_q);

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ctrl_rw_q) && $stable(ctrl_addr_q)));

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_addr == OFS_STATUS && host_wdata[ST_BIT_OVR]) |=> !ovr_q);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> $stable(data_q));

    p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < BW'(TMO_CYCLES)));
endmodule

bind ind_bridge ibr_chk #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_ibr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_en  (host_wr_en),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .busy        (busy),
    .ovr_q       (ovr_q),
    .xfer_done   (xfer_done),
    .ctrl_rw_q   (ctrl_rw_q),
    .ctrl_addr_q (ctrl_addr_q),
    .data_q      (data_q)
);

// File: tb/test_ind_bridge.sv
`timescale 1ns/1ps
module test_ind_bridge;
    localparam int LAT_A = 3;
    localparam int TMO_A = 200;
    localparam int LAT_B = 8;
    localparam int TMO_B = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr0 = 1'b0, wr1 = 1'b0;
    logic [1:0] haddr = 2'd0;
    logic [7:0] hwdata = 8'd0;
    logic [7:0] rd0, rd1;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    ind_bridge #(.LATENCY(LAT_A), .TMO_CYCLES(TMO_A)) i_ind_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr0), .host_addr(haddr),
        .host_wdata(hwdata), .host_rdata(rd0));

    ind_bridge #(.LATENCY(LAT_B), .TMO_CYCLES(TMO_B)) i_ind_bridge_tmo (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr1), .host_addr(haddr),
        .host_wdata(hwdata), .host_rdata(rd1));

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwr(int dut, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        haddr = a; hwdata = d;
        if (dut == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic hrd(int dut, logic [1:0] a, output logic [7:0] v);
        haddr = a;
        #1;
        v = (dut == 0) ? rd0 : rd1;
    endtask

    task automatic wait_idle(int dut, output int cyc);
        logic [7:0] s;
        cyc = 0;
        hrd(dut, 2'd0, s);
        while (s[0] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            hrd(dut, 2'd0, s);
        end
    endtask

    task automatic do_write(int a, logic [7:0] d);
        int c;
        hwr(0, 2'd2, d);
        hwr(0, 2'd1, 8'(a & 127));
        wait_idle(0, c);
    endtask

    task automatic do_read(int a, output logic [7:0] v);
        int c;
        hwr(0, 2'd1, 8'(8'h80 | (a & 127)));
        wait_idle(0, c);
        hrd(0, 2'd2, v);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hrd(0, 2'd0, v); chk("R1 status", v, 0);
        hrd(0, 2'd1, v); chk("R1 ctrl", v, 0);
        hrd(0, 2'd2, v); chk("R1 data", v, 0);
        hrd(0, 2'd3, v); chk("R10 unused read", v, 0);

        // R2/R3/R5: read of untouched entry
        hwr(0, 2'd1, 8'h85);
        hrd(0, 2'd0, v); chk("R2 busy after accept", v[0], 1);
        hrd(0, 2'd1, v); chk("R10 ctrl readback", v, 8'h85);
        wait_idle(0, c); chk("R3 read busy length", c, LAT_A + 1);
        hrd(0, 2'd2, v); chk("R1 array reset", v, 0);

        // R3 write busy length
        hwr(0, 2'd2, 8'h11);
        hwr(0, 2'd1, 8'h05);
        wait_idle(0, c); chk("R3 write busy length", c, LAT_A + 1);

        // R4/R5 exhaustive sweep
        for (int a = 0; a < 128; a++) do_write(a, pat(a));
        for (int a = 0; a < 128; a++) begin
            do_read(a, v);
            chk("R4 R5 sweep", v, pat(a));
        end

        // R5 data held while busy
        hwr(0, 2'd2, 8'hC3);
        hwr(0, 2'd1, 8'h80 | 8'd20);
        hrd(0, 2'd2, v); chk("R5 data held while busy", v, 8'hC3);
        wait_idle(0, c);
        hrd(0, 2'd2, v); chk("R5 data on completion", v, pat(20));

        // R6 overrun: second ctrl write while busy
        hwr(0, 2'd1, 8'h80 | 8'd30);
        hwr(0, 2'd1, 8'h80 | 8'd40);
        hrd(0, 2'd1, v); chk("R6 ctrl unchanged", v, 8'h80 | 8'd30);
        hrd(0, 2'd0, v); chk("R6 overrun set", v[1], 1);
        wait_idle(0, c);
        hrd(0, 2'd2, v); chk("R6 original transfer", v, pat(30));
        hrd(0, 2'd0, v); chk("R6 overrun sticky", v[1], 1);

        // R7 clear semantics
        hwr(0, 2'd0, 8'h00);
        hrd(0, 2'd0, v); chk("R7 write 0 keeps", v[1], 1);
        hwr(0, 2'd0, 8'h02);
        hrd(0, 2'd0, v); chk("R7 write 1 clears", v[1], 0);

        // R8 data write during write transfer
        hwr(0, 2'd2, 8'h66);
        hwr(0, 2'd1, 8'd50);
        hwr(0, 2'd2, 8'hEE);
        hrd(0, 2'd2, v); chk("R8 data ignored busy", v, 8'h66);
        wait_idle(0, c);
        do_read(50, v); chk("R8 write kept old data", v, 8'h66);
        // R8 data write during read transfer
        hwr(0, 2'd1, 8'h80 | 8'd60);
        hwr(0, 2'd2, 8'h5A);
        wait_idle(0, c);
        hrd(0, 2'd2, v); chk("R8 read returns array", v, pat(60));

        // R10 offset 3 writes ignored
        hwr(0, 2'd3, 8'hFF);
        hrd(0, 2'd0, v); chk("R10 status after ofs3", v, 0);
        hrd(0, 2'd1, v); chk("R10 ctrl after ofs3", v, 8'h80 | 8'd60);
        hrd(0, 2'd2, v); chk("R10 data after ofs3", v, pat(60));

        // R9 timeout on second instance
        hwr(1, 2'd2, 8'h3C);
        hwr(1, 2'd1, 8'h89);
        wait_idle(1, c); chk("R9 abort busy length", c, TMO_B);
        hrd(1, 2'd0, v); chk("R9 timeout flag", v, 8'h04);
        hrd(1, 2'd2, v); chk("R9 data unchanged", v, 8'h3C);
        repeat (LAT_B + 2) @(negedge clk);
        hrd(1, 2'd2, v); chk("R9 late completion dropped", v, 8'h3C);
        hwr(1, 2'd0, 8'h04);
        hrd(1, 2'd0, v); chk("R9 timeout cleared", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule